// File: doc/BRIEF.md
# Ring-Chained FIFO Slice Controller

This block is the per-slice control logic that lets several identical FIFO slices act as one deeper queue. Every slice sees the same write strobe, read strobe and data input. The slices form a ring: the pass-out pulse of one slice feeds the pass-in pin of the next, and the last slice feeds the first. Each slice keeps two ownership bits, one for writes and one for reads. Only the slice that owns writes stores the incoming word, and only the slice that owns reads supplies the next word to the shared output bus. When a slice fills its top location, or drains it, the slice hands that ownership on with a one-cycle low pulse.

The controller drives a storage array through a write port (enable and address) and a read port (enable and address). The array sits outside the block. A registered output-enable tells the array which slice owns the shared data bus in the cycle after a read. The mode pins are captured while reset is held. If the pass-in pin is low during reset, the slice runs alone as a plain FIFO with a half-full flag and a rewind-to-start function. Otherwise it joins a ring, and the slice whose first-slice pin is low starts out owning both reads and writes.

Top module: `fx_ring_ctl`

## Requirements
- R1: While `rst` is high, the slice captures `exp_in_n`. A captured 0 selects standalone mode. In standalone mode reads and writes need no ownership, and `exp_out_n` stays 1.
- R2: In ring mode, the slice with `first_load_n` = 0 at reset owns both writes and reads. Every other slice owns neither. After reset the ring reports empty (the OR of `empty_o` is 1) and not full.
- R3: In ring mode, an accepted write to address DEPTH-1 gives up write ownership. `exp_out_n` is 0 for exactly the one cycle that follows that clock edge.
- R4: In ring mode, an accepted read from address DEPTH-1 gives up read ownership, with the same one-cycle low pulse on `exp_out_n`.
- R5: A low on `exp_in_n` grants ownership in that same cycle, so a strobe on the next edge is accepted with no lost cycle. Pulses arriving at a slice alternate in meaning. The first one after reset grants writes, the next one grants reads, and so on.
- R6: A slice ignores `wr_stb` while it does not own writes, and ignores `rd_stb` while it does not own reads. It asserts no memory enable, and its pointers do not move.
- R7: `full_o` is 1 when the slice owns writes and holds DEPTH words. `empty_o` is 1 when the slice owns reads and holds none. A full slice rejects writes and an empty slice rejects reads. The OR across the ring gives the ring's full and empty flags.
- R8: `rd_oe` is 1 in the cycle that follows an accepted read, and is 0 otherwise. At most one slice in a ring asserts it at a time.
- R9: `half_o` is 1 in standalone mode when more than DEPTH/2 words are held. It is always 0 in ring mode.
- R10: In standalone mode, `rt_req` with neither strobe active moves the read pointer back to address 0, so reads replay from the first word written. This holds if no more than DEPTH writes have occurred since reset. In ring mode `rt_req` has no effect.
- R11: Words read from a ring come out in the order they were written, across any number of ownership hand-offs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode pins are captured while it is high |
| exp_in_n | input | 1 | Pass-in from the previous slice (active-low pulse); tie low for standalone mode |
| first_load_n | input | 1 | Low on the one ring slice that starts owning reads and writes |
| exp_out_n | output | 1 | Pass-out to the next slice; one-cycle low pulse on hand-off |
| wr_stb | input | 1 | Shared write strobe, one word per cycle |
| rd_stb | input | 1 | Shared read strobe, one word per cycle |
| rt_req | input | 1 | Rewind read pointer to address 0 (standalone mode only) |
| mem_we | output | 1 | Storage write enable |
| mem_waddr | output | $clog2(DEPTH) | Storage write address |
| mem_re | output | 1 | Storage read enable |
| mem_raddr | output | $clog2(DEPTH) | Storage read address |
| rd_oe | output | 1 | Registered drive enable for the shared output bus |
| full_o | output | 1 | Write owner with no free location |
| empty_o | output | 1 | Read owner with no stored word |
| half_o | output | 1 | More than half full (standalone mode only) |

## Verification
The assertions check these properties on every cycle:
- the pass-out pulse is exactly one cycle wide;
- a write or read at the top address produces that pulse;
- a standalone slice never pulses;
- the full and empty flags block the memory enables;
- the output-enable follows an accepted read by one cycle;
- the half flag stays low in ring mode.

Only the bench scenarios can show the end-to-end ring properties. These are that three chained slices keep the words in order across hand-offs, that the slice receiving a pulse takes the very next strobe, that the ring's combined flags match a reference occupancy model, and that rewind replays data in standalone mode but changes nothing in a ring.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic {MODE_SOLO = 1'b0, MODE_RING = 1'b1} ring_mode_e;
endpackage

// File: rtl/fx_mode_latch.sv
module fx_mode_latch
  import fx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       exp_in_n,
  output ring_mode_e mode_q
);
  // R1: the pass-in level seen during reset picks the mode; held afterwards
  always_ff @(posedge clk) begin
    if (rst) mode_q <= exp_in_n ? MODE_RING : MODE_SOLO;
  end
endmodule

// File: rtl/fx_token_ctl.sv
module fx_token_ctl
  import fx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ring_mode_e mode,
  input  logic       exp_in_n,
  input  logic       first_load_n,
  input  logic       w_last,
  input  logic       r_last,
  output logic       own_w,
  output logic       own_r,
  output logic       exp_out_n
);
  logic wtok_q, rtok_q, expect_rd_q;
  logic arrive, w_arrive, r_arrive;

  assign arrive   = (mode == MODE_RING) && !exp_in_n;
  assign w_arrive = arrive && !expect_rd_q;
  assign r_arrive = arrive && expect_rd_q;

  // R5: an arriving pulse grants ownership in the same cycle
  assign own_w = (mode == MODE_SOLO) || wtok_q || w_arrive;
  assign own_r = (mode == MODE_SOLO) || rtok_q || r_arrive;

  always_ff @(posedge clk) begin
    if (rst) begin
      // R2: only the designated first slice of a ring starts with both
      wtok_q      <= exp_in_n && !first_load_n;
      rtok_q      <= exp_in_n && !first_load_n;
      expect_rd_q <= 1'b0;
      exp_out_n   <= 1'b1;
    end else begin
      wtok_q      <= (wtok_q || w_arrive) && !w_last;
      rtok_q      <= (rtok_q || r_arrive) && !r_last;
      expect_rd_q <= arrive ? !expect_rd_q : expect_rd_q;
      exp_out_n   <= !(w_last || r_last);
    end
  end
endmodule

// File: rtl/fx_ptr_ctl.sv
module fx_ptr_ctl #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ok,
  input  logic          rd_ok,
  input  logic          rt_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count
);
  logic [CW-1:0] wptr_x, rptr_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_x <= '0;
      rptr_x <= '0;
    end else begin
      if (wr_ok) wptr_x <= wptr_x + 1'b1;
      if (rt_ok)      rptr_x <= '0;             // R10
      else if (rd_ok) rptr_x <= rptr_x + 1'b1;
    end
  end

  assign waddr = wptr_x[AW-1:0];
  assign raddr = rptr_x[AW-1:0];
  assign count = wptr_x - rptr_x;
endmodule

// File: rtl/fx_ring_ctl.sv
module fx_ring_ctl
  import fx_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exp_in_n,
  input  logic          first_load_n,
  output logic          exp_out_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          rt_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          rd_oe,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  ring_mode_e    mode;
  logic          ring_mode;
  logic          own_w, own_r;
  logic          wr_ok, rd_ok, rt_ok, w_last, r_last;
  logic [CW-1:0] count;
  logic          is_full, is_empty;

  fx_mode_latch u_mode (
    .clk(clk), .rst(rst), .exp_in_n(exp_in_n), .mode_q(mode)
  );

  assign ring_mode = (mode == MODE_RING);
  assign is_full   = (count == CNT_FULL);
  assign is_empty  = (count == '0);

  // R6/R7: strobes count only for the owner with room or data
  assign wr_ok  = wr_stb && own_w && !is_full;
  assign rd_ok  = rd_stb && own_r && !is_empty;
  assign rt_ok  = rt_req && !ring_mode && !wr_stb && !rd_stb;
  assign w_last = wr_ok && ring_mode && (mem_waddr == TOP_ADDR);
  assign r_last = rd_ok && ring_mode && (mem_raddr == TOP_ADDR);

  fx_token_ctl u_tok (
    .clk(clk), .rst(rst), .mode(mode), .exp_in_n(exp_in_n),
    .first_load_n(first_load_n), .w_last(w_last), .r_last(r_last),
    .own_w(own_w), .own_r(own_r), .exp_out_n(exp_out_n)
  );

  fx_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd_ok(rd_ok), .rt_ok(rt_ok),
    .waddr(mem_waddr), .raddr(mem_raddr), .count(count)
  );

  assign mem_we  = wr_ok;
  assign mem_re  = rd_ok;
  assign full_o  = own_w && is_full;
  assign empty_o = own_r && is_empty;
  assign half_o  = !ring_mode && (count > CNT_HALF);   // R9

  // R8: bus drive lines up with the array's registered read data
  always_ff @(posedge clk) begin
    if (rst) rd_oe <= 1'b0;
    else     rd_oe <= rd_ok;
  end
endmodule

// File: rtl/fx_ring_ctl_chk.sv
module fx_ring_ctl_chk #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          ring,
  input logic          exp_out_n,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic          mem_re,
  input logic [AW-1:0] mem_raddr,
  input logic          rd_oe,
  input logic          full_o,
  input logic          empty_o,
  input logic          half_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !exp_out_n |=> exp_out_n);
  a_r3_write_hands_off: assert property (@(posedge clk) disable iff (rst)
    (ring && mem_we && mem_waddr == TOP) |=> !exp_out_n);
  a_r4_read_hands_off: assert property (@(posedge clk) disable iff (rst)
    (ring && mem_re && mem_raddr == TOP) |=> !exp_out_n);
  a_r1_solo_never_pulses: assert property (@(posedge clk) disable iff (rst)
    !ring |-> exp_out_n);
  a_r7_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
    full_o |-> !mem_we);
  a_r7_empty_blocks_read: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> !mem_re);
  a_r8_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> rd_oe);
  a_r8_oe_idle: assert property (@(posedge clk) disable iff (rst)
    !mem_re |=> !rd_oe);
  a_r9_half_solo_only: assert property (@(posedge clk) disable iff (rst)
    ring |-> !half_o);
endmodule

bind fx_ring_ctl fx_ring_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ring(ring_mode), .exp_out_n(exp_out_n),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_re(mem_re),
  .mem_raddr(mem_raddr), .rd_oe(rd_oe), .full_o(full_o),
  .empty_o(empty_o), .half_o(half_o)
);

// File: tb/tb_fx_ring_ctl.sv
module tb_fx_ring_ctl;
  localparam int D = 4;
  localparam int N = 3;
  localparam int CAP = D * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic wr = 0, rd = 0, rt = 0;
  logic [7:0] din = 0;
  logic [N-1:0] xo, we, re, oe, fu, em, hf;
  logic [1:0] wa [N];
  logic [1:0] ra [N];
  logic [7:0] mem [N][D];
  logic [7:0] q [N];

  // single-mode slice
  logic s_wr = 0, s_rd = 0, s_rt = 0;
  logic s_xo, s_we, s_re, s_oe, s_fu, s_em, s_hf;
  logic [1:0] s_wa, s_ra;
  logic [7:0] smem [D];
  logic [7:0] sq;

  fx_ring_ctl #(.DEPTH(D)) dut (
    .clk(clk), .rst(rst), .exp_in_n(xo[2]), .first_load_n(1'b0),
    .exp_out_n(xo[0]), .wr_stb(wr), .rd_stb(rd), .rt_req(rt),
    .mem_we(we[0]), .mem_waddr(wa[0]), .mem_re(re[0]), .mem_raddr(ra[0]),
    .rd_oe(oe[0]), .full_o(fu[0]), .empty_o(em[0]), .half_o(hf[0]));
  fx_ring_ctl #(.DEPTH(D)) u_s1 (
    .clk(clk), .rst(rst), .exp_in_n(xo[0]), .first_load_n(1'b1),
    .exp_out_n(xo[1]), .wr_stb(wr), .rd_stb(rd), .rt_req(rt),
    .mem_we(we[1]), .mem_waddr(wa[1]), .mem_re(re[1]), .mem_raddr(ra[1]),
    .rd_oe(oe[1]), .full_o(fu[1]), .empty_o(em[1]), .half_o(hf[1]));
  fx_ring_ctl #(.DEPTH(D)) u_s2 (
    .clk(clk), .rst(rst), .exp_in_n(xo[1]), .first_load_n(1'b1),
    .exp_out_n(xo[2]), .wr_stb(wr), .rd_stb(rd), .rt_req(rt),
    .mem_we(we[2]), .mem_waddr(wa[2]), .mem_re(re[2]), .mem_raddr(ra[2]),
    .rd_oe(oe[2]), .full_o(fu[2]), .empty_o(em[2]), .half_o(hf[2]));
  fx_ring_ctl #(.DEPTH(D)) u_solo (
    .clk(clk), .rst(rst), .exp_in_n(1'b0), .first_load_n(1'b1),
    .exp_out_n(s_xo), .wr_stb(s_wr), .rd_stb(s_rd), .rt_req(s_rt),
    .mem_we(s_we), .mem_waddr(s_wa), .mem_re(s_re), .mem_raddr(s_ra),
    .rd_oe(s_oe), .full_o(s_fu), .empty_o(s_em), .half_o(s_hf));

  // storage arrays (outside the block)
  always @(posedge clk) begin
    for (int s = 0; s < N; s++) begin
      if (we[s]) mem[s][wa[s]] <= din;
      if (re[s]) q[s] <= mem[s][ra[s]];
    end
    if (s_we) smem[s_wa] <= din;
    if (s_re) sq <= smem[s_ra];
  end

  logic [7:0] bus, s_bus;
  always_comb begin
    bus = '0;
    for (int s = 0; s < N; s++) if (oe[s]) bus = bus | q[s];
    s_bus = s_oe ? sq : 8'h00;
  end

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] sb [$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one ring cycle with reference model
  logic [N-1:0] we_snap;
  task automatic step(input logic w, input logic r, input logic [7:0] d, input logic t);
    bit aw, ar;
    logic [7:0] ev;
    aw = w && (sb.size() < CAP);
    ar = r && (sb.size() > 0);
    ev = ar ? sb[0] : 8'h00;
    wr = w; rd = r; din = d; rt = t;
    #5;
    we_snap = we;
    chk("R6 R7 write enables", $countones(we), int'(aw));
    chk("R6 R7 read enables", $countones(re), int'(ar));
    @(posedge clk);
    @(negedge clk);
    wr = 0; rd = 0; rt = 0;
    if (ar) void'(sb.pop_front());
    if (aw) sb.push_back(d);
    chk("R8 one bus driver", $countones(oe), int'(ar));
    if (ar) chk("R11 read order", bus, ev);
    chk("R7 ring full", int'(|fu), int'(sb.size() == CAP));
    chk("R7 ring empty", int'(|em), int'(sb.size() == 0));
    chk("R9 no half in ring", int'(|hf), 0);
  endtask

  task automatic t_reset;
    chk("R2 empty after reset", int'(|em), 1);
    chk("R2 not full after reset", int'(|fu), 0);
    chk("R2 first slice owns reads", int'(em[0]), 1);
    chk("R3 pass-outs idle", int'(xo), 3'b111);
    chk("R1 solo empty", int'(s_em), 1);
  endtask

  task automatic t_fill_drain;
    for (int i = 0; i < CAP; i++) begin
      step(1, 0, 8'(8'h20 + i), 0);
      if (i == 0) chk("R6 non-owners ignore write", int'(we_snap[2:1]), 0);
      if (i == D - 1) chk("R3 pulse after top write", int'(xo[0]), 0);
      if (i == D) begin
        chk("R5 next slice takes next strobe", int'(we_snap), 3'b010);
        chk("R3 pulse is one cycle", int'(xo[0]), 1);
      end
    end
    step(1, 0, 8'hEE, 0);  // rejected: ring full
    chk("R7 extra write rejected", sb.size(), CAP);
    step(0, 0, 8'h00, 1);  // rewind ignored in ring
    for (int i = 0; i < CAP; i++) begin
      step(0, 1, 8'h00, 0);
      if (i == D - 1) chk("R4 pulse after top read", int'(xo[0]), 0);
      if (i == 0) chk("R10 rewind ignored in ring", bus, 8'h20);
    end
    step(0, 1, 8'h00, 0);  // rejected: ring empty
    chk("R7 extra read rejected", int'(|oe), 0);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 90; i++)
      step((i % 5) != 4, (i % 3) != 0 || i > 60, 8'(i + 8'h40), 0);
    while (sb.size() > 0) step(0, 1, 8'h00, 0);
    chk("R11 stream drained", sb.size(), 0);
  endtask

  task automatic solo_step(input logic w, input logic r, input logic t, input logic [7:0] d);
    s_wr = w; s_rd = r; s_rt = t; din = d;
    @(posedge clk);
    @(negedge clk);
    s_wr = 0; s_rd = 0; s_rt = 0;
  endtask

  task automatic t_solo;
    solo_step(1, 0, 0, 8'h10);
    solo_step(1, 0, 0, 8'h11);
    chk("R9 half at DEPTH/2", int'(s_hf), 0);
    solo_step(1, 0, 0, 8'h12);
    chk("R9 half above DEPTH/2", int'(s_hf), 1);
    chk("R1 solo pass-out idle", int'(s_xo), 1);
    solo_step(0, 1, 0, 8'h00);
    chk("R8 solo read data", s_bus, 8'h10);
    solo_step(0, 1, 0, 8'h00);
    chk("R8 solo read data 2", s_bus, 8'h11);
    solo_step(0, 0, 1, 8'h00);
    solo_step(0, 1, 0, 8'h00);
    chk("R10 rewind replays first word", s_bus, 8'h10);
    solo_step(1, 0, 0, 8'h13);
    solo_step(1, 0, 0, 8'h14);
    chk("R7 solo full", int'(s_fu), 1);
    chk("R1 solo never pulses", int'(s_xo), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_fill_drain();
    t_stream();
    t_solo();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule